// File: doc/BRIEF.md
# Kernel launch warp formation unit

This unit turns a one-dimensional kernel launch into a stream of warp descriptors. A launch gives a block count and a block size in threads. The unit cuts every block into warps of consecutive threads, starting at thread 0 of that block. It hands one warp per cycle to a downstream scheduler over a valid/ready handshake.

Every descriptor carries five fields: the block number, the warp number inside that block, the local thread number of lane 0, the grid-wide thread number of lane 0, and a lane activity mask. A warp never crosses a block boundary. When the block size is not a multiple of the warp width, the lanes that fall past the end of the block are cleared in the mask of the block's last warp. The unit takes a new launch only while it is idle. It reports the end of each launch with a single-cycle completion pulse.

Top module: `warp_former`

## Requirements
- R1: While reset is held and in the first cycle after reset is released, `warpValid` and `done` are 0 and `launchReady` is 1.
- R2: A launch is taken only when `launchValid` and `launchReady` are both high at a clock edge. `launchReady` is low while warps of a launch are pending, and a launch offered during that time has no effect on the descriptors that are emitted.
- R3: Descriptors come out in ascending block order and, inside a block, in ascending warp order. A block of T threads yields ceil(T / WARP_SIZE) warps.
- R4: `warpThread0` equals `warpIndex` times WARP_SIZE.
- R5: `warpGlobal0` equals `warpBlock` times the block size plus `warpThread0`.
- R6: Bit i of `warpMask` (bit 0 = lane 0) is 1 exactly when `warpThread0` + i is less than the block size. Active lanes are always the low, contiguous lanes.
- R7: The first warp of every block has `warpIndex` 0 and `warpThread0` 0. No warp holds threads of two blocks.
- R8: While `warpValid` is high and `warpReady` is low, every descriptor field holds its value. When both are high, exactly one descriptor transfers at that edge.
- R9: `done` is high for exactly one cycle, the cycle after the final warp of the final block transfers. `launchReady` is 1 in that cycle.
- R10: A launch with zero blocks or zero threads per block emits no warp and raises `done` in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Launch request |
| launchReady | output | 1 | Unit is idle and can take a launch |
| launchBlocks | input | BLK_W | Number of blocks in the launch |
| launchThreads | input | THR_W | Threads per block |
| warpValid | output | 1 | Descriptor available |
| warpReady | input | 1 | Downstream takes the descriptor |
| warpBlock | output | BLK_W | Block number of the warp |
| warpIndex | output | THR_W | Warp number inside its block |
| warpThread0 | output | THR_W | Local thread number of lane 0 |
| warpGlobal0 | output | BLK_W+THR_W | Grid-wide thread number of lane 0 |
| warpMask | output | WARP_SIZE | Lane activity mask, bit i = lane i |
| done | output | 1 | One-cycle launch-complete pulse |

## Verification
The bench uses a warp width of 3 and walks a table of launches. An exact multiple of the width (3×6) checks global numbering with full warps only. Block sizes of 5 and 7 give a partial last warp and separate a correct per-block restart from a running count across blocks. A single thread and a block smaller than a warp (4×2) test a one-lane mask and many one-warp blocks. Directed cases cover back-pressure hold, a launch offered while the unit is busy, and empty launches with zero blocks and with zero threads.

// File: rtl/wf_pkg.sv
package wf_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture a new launch
    logic advWarp;   // next warp in the same block
    logic advBlock;  // first warp of the next block
  } wf_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } wf_state_e;
endpackage

// File: rtl/wf_ctrl.sv
module wf_ctrl
  import wf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       launchValid,
  input  logic       launchEmpty,
  input  logic       warpReady,
  input  logic       lastWarp,
  input  logic       lastBlock,
  output logic       launchReady,
  output logic       warpValid,
  output logic       done,
  output wf_strobe_t strobe
);
  wf_state_e state;
  logic accept;
  logic fire;
  logic finish;

  always_comb begin
    accept          = (state == ST_IDLE) && launchValid;
    fire            = (state == ST_EMIT) && warpReady;
    finish          = fire && lastWarp && lastBlock;
    strobe.load     = accept && !launchEmpty;
    strobe.advWarp  = fire && !lastWarp;
    strobe.advBlock = fire && lastWarp && !lastBlock;
    launchReady     = (state == ST_IDLE);
    warpValid       = (state == ST_EMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= (accept && launchEmpty) || finish;
      if (strobe.load)  state <= ST_EMIT;
      else if (finish)  state <= ST_IDLE;
    end
  end

  // R10
  empty_launch_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (launchReady && launchValid && launchEmpty) |=> (done && launchReady));

  // R9
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> launchReady);
endmodule

// File: rtl/wf_datapath.sv
module wf_datapath
  import wf_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int BLK_W     = 10,
  parameter int THR_W     = 11,
  localparam int GLB_W    = BLK_W + THR_W
)(
  input  logic             clk,
  input  logic             rstN,
  input  wf_strobe_t       strobe,
  input  logic [BLK_W-1:0] launchBlocks,
  input  logic [THR_W-1:0] launchThreads,
  output logic             launchEmpty,
  output logic             lastWarp,
  output logic             lastBlock,
  output logic [BLK_W-1:0] blkIdx,
  output logic [THR_W-1:0] warpIdx,
  output logic [THR_W-1:0] thr0,
  output logic [GLB_W-1:0] glob0,
  output logic [WARP_SIZE-1:0] mask
);
  localparam logic [THR_W:0]   WS_EXT = (THR_W+1)'(WARP_SIZE);
  localparam logic [THR_W-1:0] WS_STEP = THR_W'(WARP_SIZE);

  logic [BLK_W-1:0] nBlocks;
  logic [THR_W-1:0] nThreads;
  logic [GLB_W-1:0] blockBase;
  logic [THR_W:0]   remaining;

  always_comb begin
    launchEmpty = (launchBlocks == '0) || (launchThreads == '0);
    remaining   = {1'b0, nThreads} - {1'b0, thr0};
    lastWarp    = (remaining <= WS_EXT);
    lastBlock   = (blkIdx == nBlocks - BLK_W'(1));
    glob0       = blockBase + {{BLK_W{1'b0}}, thr0};
  end

  // one comparator per lane
  for (genvar l = 0; l < WARP_SIZE; l++) begin : g_lane
    assign mask[l] = (remaining > (THR_W+1)'(l));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nBlocks   <= '0;
      nThreads  <= '0;
      blkIdx    <= '0;
      warpIdx   <= '0;
      thr0      <= '0;
      blockBase <= '0;
    end else if (strobe.load) begin
      nBlocks   <= launchBlocks;
      nThreads  <= launchThreads;
      blkIdx    <= '0;
      warpIdx   <= '0;
      thr0      <= '0;
      blockBase <= '0;
    end else if (strobe.advBlock) begin
      blkIdx    <= blkIdx + BLK_W'(1);
      warpIdx   <= '0;
      thr0      <= '0;
      blockBase <= blockBase + {{BLK_W{1'b0}}, nThreads};
    end else if (strobe.advWarp) begin
      warpIdx   <= warpIdx + THR_W'(1);
      thr0      <= thr0 + WS_STEP;
    end
  end

  // R4
  lane0_matches_warp_chk: assert property (@(posedge clk) disable iff (!rstN)
    thr0 == THR_W'(warpIdx * WS_STEP));
endmodule

// File: rtl/warp_former.sv
module warp_former
  import wf_pkg::*;
#(
  parameter int WARP_SIZE = 32,
  parameter int BLK_W     = 10,
  parameter int THR_W     = 11
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   launchValid,
  output logic                   launchReady,
  input  logic [BLK_W-1:0]       launchBlocks,
  input  logic [THR_W-1:0]       launchThreads,
  output logic                   warpValid,
  input  logic                   warpReady,
  output logic [BLK_W-1:0]       warpBlock,
  output logic [THR_W-1:0]       warpIndex,
  output logic [THR_W-1:0]       warpThread0,
  output logic [BLK_W+THR_W-1:0] warpGlobal0,
  output logic [WARP_SIZE-1:0]   warpMask,
  output logic                   done
);
  wf_strobe_t strobe;
  logic launchEmpty;
  logic lastWarp;
  logic lastBlock;

  wf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .launchValid(launchValid),
    .launchEmpty(launchEmpty), .warpReady(warpReady),
    .lastWarp(lastWarp), .lastBlock(lastBlock),
    .launchReady(launchReady), .warpValid(warpValid),
    .done(done), .strobe(strobe)
  );

  wf_datapath #(.WARP_SIZE(WARP_SIZE), .BLK_W(BLK_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .launchBlocks(launchBlocks), .launchThreads(launchThreads),
    .launchEmpty(launchEmpty), .lastWarp(lastWarp), .lastBlock(lastBlock),
    .blkIdx(warpBlock), .warpIdx(warpIndex), .thr0(warpThread0),
    .glob0(warpGlobal0), .mask(warpMask)
  );

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warpValid && !warpReady) |=> (warpValid && $stable(warpBlock) &&
      $stable(warpIndex) && $stable(warpGlobal0) && $stable(warpMask)));

  // R6
  mask_contiguous_chk: assert property (@(posedge clk) disable iff (!rstN)
    warpValid |-> (warpMask[0] && ((warpMask & (warpMask + 1'b1)) == '0)));

  // R7
  block_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warpValid && warpIndex == '0) |-> (warpThread0 == '0));

  // R2
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    warpValid |-> !launchReady);
endmodule

// File: tb/warp_former_tb.sv
module warp_former_tb;
  localparam int WS = 3;
  localparam int BW = 4;
  localparam int TW = 5;
  localparam int GW = BW + TW;
  localparam int NV = 6;
  // launch table: blocks, threads per block, expected warp total
  localparam int TB_BLK[NV] = '{3, 2, 1, 2, 1, 4};
  localparam int TB_THR[NV] = '{6, 5, 1, 7, 3, 2};
  localparam int TB_NW [NV] = '{6, 4, 1, 6, 1, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0;
  logic launchReady;
  logic [BW-1:0] launchBlocks = '0;
  logic [TW-1:0] launchThreads = '0;
  logic warpValid;
  logic warpReady = 1'b1;
  logic [BW-1:0] warpBlock;
  logic [TW-1:0] warpIndex;
  logic [TW-1:0] warpThread0;
  logic [GW-1:0] warpGlobal0;
  logic [WS-1:0] warpMask;
  logic done;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  warp_former #(.WARP_SIZE(WS), .BLK_W(BW), .THR_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .launchReady(launchReady),
    .launchBlocks(launchBlocks), .launchThreads(launchThreads),
    .warpValid(warpValid), .warpReady(warpReady), .warpBlock(warpBlock),
    .warpIndex(warpIndex), .warpThread0(warpThread0), .warpGlobal0(warpGlobal0),
    .warpMask(warpMask), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks + 1, nFail);
      $finish;
    end
  end

  task automatic checkWarp(input int b, input int w, input int nt);
    int t0 = w * WS;
    int m = 0;
    for (int l = 0; l < WS; l++) if (t0 + l < nt) m |= (1 << l);
    chk(warpValid == 1'b1, "R3 valid", int'(warpValid), 1);
    chk(int'(warpBlock) == b, "R3 block", int'(warpBlock), b);
    chk(int'(warpIndex) == w, "R3 warp", int'(warpIndex), w);
    chk(int'(warpThread0) == t0, (w == 0) ? "R7 thread0" : "R4 thread0", int'(warpThread0), t0);
    chk(int'(warpGlobal0) == b * nt + t0, "R5 global", int'(warpGlobal0), b * nt + t0);
    chk(int'(warpMask) == m, "R6 mask", int'(warpMask), m);
  endtask

  // stall: hold ready low on the first warp; busy: offer a launch while emitting
  task automatic runLaunch(input int nb, input int nt, input bit stall, input bit busy,
                           output int count);
    count = 0;
    @(negedge clk);
    chk(launchReady == 1'b1, "R2 ready idle", int'(launchReady), 1);
    launchValid = 1'b1;
    launchBlocks = BW'(nb);
    launchThreads = TW'(nt);
    @(negedge clk);
    launchValid = 1'b0;
    if (nb == 0 || nt == 0) begin
      chk(done == 1'b1, "R10 done", int'(done), 1);
      chk(warpValid == 1'b0, "R10 no warp", int'(warpValid), 0);
      @(negedge clk);
      chk(warpValid == 1'b0, "R10 still no warp", int'(warpValid), 0);
      return;
    end
    chk(launchReady == 1'b0, "R2 busy", int'(launchReady), 0);
    for (int b = 0; b < nb; b++) begin
      for (int w = 0; w * WS < nt; w++) begin
        checkWarp(b, w, nt);
        count++;
        if (stall && b == 0 && w == 0) begin
          warpReady = 1'b0;
          repeat (2) begin
            @(negedge clk);
            checkWarp(b, w, nt);  // R8 hold
          end
          warpReady = 1'b1;
        end
        if (busy && b == 0 && w == 0) begin
          launchValid = 1'b1;
          launchBlocks = BW'(1);
          launchThreads = TW'(1);
        end else begin
          launchValid = 1'b0;
        end
        @(negedge clk);
        if (!(b == nb - 1 && (w + 1) * WS >= nt))
          chk(done == 1'b0, "R9 no early done", int'(done), 0);
      end
    end
    launchValid = 1'b0;
    chk(done == 1'b1, "R9 done pulse", int'(done), 1);
    chk(warpValid == 1'b0, "R9 idle", int'(warpValid), 0);
    chk(launchReady == 1'b1, "R9 ready", int'(launchReady), 1);
    @(negedge clk);
    chk(done == 1'b0, "R9 single cycle", int'(done), 0);
    chk(warpValid == 1'b0, "R2 busy launch ignored", int'(warpValid), 0);
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(warpValid == 1'b0, "R1 valid in reset", int'(warpValid), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(launchReady == 1'b1, "R1 ready in reset", int'(launchReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(warpValid == 1'b0, "R1 valid after reset", int'(warpValid), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      runLaunch(TB_BLK[i], TB_THR[i], 1'b0, 1'b0, cnt);
      chk(cnt == TB_NW[i], "R3 warp count", cnt, TB_NW[i]);
    end

    // back-pressure hold on a partial-warp launch
    runLaunch(2, 5, 1'b1, 1'b0, cnt);
    chk(cnt == 4, "R8 count with stall", cnt, 4);
    // launch offered while busy
    runLaunch(3, 6, 1'b0, 1'b1, cnt);
    chk(cnt == 6, "R2 count with busy offer", cnt, 6);
    // empty launches
    runLaunch(0, 5, 1'b0, 1'b0, cnt);
    runLaunch(2, 0, 1'b0, 1'b0, cnt);
    // unit still works after empty launches
    runLaunch(1, 4, 1'b0, 1'b0, cnt);
    chk(cnt == 2, "R10 recovery count", cnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule